// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a cycle-level model of a byte-wide parallel NOR flash. It sits behind a simple write strobe (address and data) and a registered read port. Its command decoder watches for a three-write unlock sequence. A completed sequence changes the device mode: normal array access, identification readout, or a boot-block state that the next write leaves. A sequence that breaks part way through is not lost. The bytes it had already taken are replayed as ordinary data writes, followed by the byte that broke it.

Data writes in normal mode do not reach the array directly. They fill a one-page staging buffer. Once the write side has been quiet for a fixed number of clock cycles, the whole buffer is copied into the page that the last write addressed, and the buffer is refilled with erased bytes. The device can occupy both byte lanes of a 16-bit bus, or only the even lane, or only the odd lane.

Top module: `nor_flash_seq`

## Requirements
- R1: After reset every array byte reads 0xFF, the mode is normal, and `rd_data_o` is 0xFF.
- R2: The sequence is 0xAA written to device address 0x5555, then 0x55 written to 0x2AAA, then a command byte written to 0x5555, with addresses taken modulo the device size. With the alternate flag clear, command 0x90 enters identification mode, 0xF0 returns to normal mode and 0x80 sets the alternate flag.
- R3: With the alternate flag set, command 0x60 enters identification mode and 0x40 enters boot-block mode. Any other code is a no-op, 0x90 included. The flag clears after that one completed command.
- R4: In identification mode, device offset 0 reads `ID_CODE[15:8]`, offset 1 reads `ID_CODE[7:0]`, and every other offset reads 0xFE. Data writes are ignored.
- R5: When the first unlock step is followed by a write that does not continue the sequence, data writes of 0xAA at 0x5555 and then the current byte are performed. The sequencer then returns to idle.
- R6: When the second unlock step is followed by a write to an address other than 0x5555, data writes of 0xAA at 0x5555, 0x55 at 0x2AAA and then the current byte are performed, in that order.
- R7: A normal-mode data write stores its byte in the staging buffer at the address modulo the page size (2^PAGE_W). It also makes the addressed page the commit target. Array reads do not see the buffer.
- R8: Exactly QUIET_CYC clock cycles after the last buffer write, the full buffer is copied into the target page, and bytes never written read 0xFF. The buffer then returns to all 0xFF.
- R9: Each new buffer write restarts the quiet count. The target page follows the most recent write, so earlier buffered bytes land in that page.
- R10: A write on the cycle the quiet count expires goes into a fresh buffer. The previous contents commit to the previous target page.
- R11: In boot-block mode reads return 0xFF. The next data write is discarded and returns the device to normal mode.
- R12: With LANE=1 (even only) or LANE=2 (odd only), the device address is the bus address shifted right by one. Reads on the other lane return 0xFF and writes there are ignored. With LANE=0, bus address bit ADDR_W is ignored.
- R13: `rd_data_o` updates one cycle after a read with `rd_en_i` high and holds otherwise. A read on the commit edge returns the pre-commit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W+1 | Write bus byte address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W+1 | Read bus byte address |
| rd_data_o | output | 8 | Read data, registered |

## Verification
The bench lands a fresh data write in a different page on exactly the cycle the quiet count of an earlier write expires, so a buffer commit and a buffer fill meet on one edge. Correct handling puts the old byte in the old page and the new byte alone in the new page. A design that merged the two would place the new byte at the same offset in the old page instead, and the full-array sweep that follows catches that. A second coincidence, a read on the commit edge, is judged by stepping a read across the expiry one cycle at a time.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_IDENT, MODE_BOOT} mode_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_GOT1, SEQ_GOT2} seq_e;
  localparam int LANE_BOTH = 0;
  localparam int LANE_EVEN = 1;
  localparam int LANE_ODD  = 2;
  localparam int SLOTS     = 3;
endpackage

// File: rtl/nor_lane_map.sv
module nor_lane_map #(
  parameter int ADDR_W = 8,
  parameter int LANE   = 0
) (
  input  logic [ADDR_W:0]   bus_addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  import nor_flash_pkg::*;

  generate
    if (LANE == LANE_BOTH) begin : g_both
      logic unused_hi;
      assign unused_hi  = bus_addr_i[ADDR_W];
      assign hit_o      = 1'b1;
      assign dev_addr_o = bus_addr_i[ADDR_W-1:0];
    end else begin : g_single
      assign hit_o      = (LANE == LANE_ODD) ? bus_addr_i[0] : ~bus_addr_i[0];
      assign dev_addr_o = bus_addr_i[ADDR_W:1];
    end
  endgenerate
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [7:0]                    data_i,
  output logic [SLOTS-1:0]              slot_vld_o,
  output logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr_o,
  output logic [SLOTS-1:0][7:0]         slot_data_o,
  output mode_e                         mode_o,
  output seq_e                          stage_o
);
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] UNLK_B = ADDR_W'(16'h2AAA);

  seq_e  stage_q, stage_d;
  mode_e mode_q, mode_d, mode_cmd, walk;
  logic  alt_q, alt_d;
  logic [SLOTS-1:0] raw_vld;

  always_comb begin
    stage_d     = stage_q;
    alt_d       = alt_q;
    mode_cmd    = mode_q;
    raw_vld     = '0;
    slot_addr_o = '0;
    slot_data_o = '0;
    if (wr_i) begin
      case (stage_q)
        SEQ_IDLE: begin
          if (data_i == 8'hAA && addr_i == UNLK_A) stage_d = SEQ_GOT1;
          else begin
            raw_vld[0] = 1'b1; slot_addr_o[0] = addr_i; slot_data_o[0] = data_i;
          end
        end
        SEQ_GOT1: begin
          stage_d = SEQ_IDLE;
          if (data_i == 8'h55 && addr_i == UNLK_B) stage_d = SEQ_GOT2;
          else begin
            raw_vld[1:0]   = 2'b11;
            slot_addr_o[0] = UNLK_A; slot_data_o[0] = 8'hAA;
            slot_addr_o[1] = addr_i; slot_data_o[1] = data_i;
          end
        end
        default: begin
          stage_d = SEQ_IDLE;
          if (addr_i == UNLK_A) begin
            if (alt_q) begin
              alt_d = 1'b0;
              case (data_i)
                8'h40:   mode_cmd = MODE_BOOT;
                8'h60:   mode_cmd = MODE_IDENT;
                default: ;
              endcase
            end else begin
              case (data_i)
                8'h80:   alt_d = 1'b1;
                8'h90:   mode_cmd = MODE_IDENT;
                8'hF0:   mode_cmd = MODE_ARRAY;
                default: ;
              endcase
            end
          end else begin
            raw_vld        = 3'b111;
            slot_addr_o[0] = UNLK_A; slot_data_o[0] = 8'hAA;
            slot_addr_o[1] = UNLK_B; slot_data_o[1] = 8'h55;
            slot_addr_o[2] = addr_i; slot_data_o[2] = data_i;
          end
        end
      endcase
    end
  end

  // replayed bytes see the mode left behind by the byte before them
  always_comb begin
    walk       = mode_cmd;
    slot_vld_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (raw_vld[i]) begin
        case (walk)
          MODE_ARRAY: slot_vld_o[i] = 1'b1;
          MODE_BOOT:  walk = MODE_ARRAY;
          default:    ;
        endcase
      end
    end
    mode_d = walk;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= SEQ_IDLE;
      mode_q  <= MODE_ARRAY;
      alt_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      mode_q  <= mode_d;
      alt_q   <= alt_d;
    end
  end

  assign mode_o  = mode_q;
  assign stage_o = stage_q;
endmodule

// File: rtl/nor_page_store.sv
module nor_page_store
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int QUIET_CYC = 10690
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SLOTS-1:0]              slot_vld_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr_i,
  input  logic [SLOTS-1:0][7:0]         slot_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [7:0]                    rd_byte_o,
  output logic                          buf_wr_o,
  output logic                          commit_o
);
  localparam int PAGE_B = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(QUIET_CYC);

  logic [PAGE_B-1:0][7:0] pg_q, pg_d;
  logic [BASE_W-1:0]      base_q, base_d;
  logic                   pend_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [7:0]             mem_q [DEPTH];

  assign commit_o = pend_q && (cnt_q == '0);

  // commit empties the buffer first; same-cycle writes land in the fresh one
  always_comb begin
    pg_d     = commit_o ? '1 : pg_q;
    base_d   = base_q;
    buf_wr_o = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_vld_i[i]) begin
        pg_d[slot_addr_i[i][PAGE_W-1:0]] = slot_data_i[i];
        base_d   = slot_addr_i[i][ADDR_W-1:PAGE_W];
        buf_wr_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q   <= '1;
      base_q <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pg_q   <= pg_d;
      base_q <= base_d;
      if (buf_wr_o) begin
        pend_q <= 1'b1;
        cnt_q  <= CNT_W'(QUIET_CYC - 1);
      end else if (commit_o) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= 8'hFF;
    end else if (commit_o) begin
      for (int j = 0; j < PAGE_B; j++) mem_q[{base_q, PAGE_W'(j)}] <= pg_q[j];
    end
  end

  assign rd_byte_o = mem_q[rd_addr_i];
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
  import nor_flash_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          PAGE_W    = 3,
  parameter int          QUIET_CYC = 10690,
  parameter logic [15:0] ID_CODE   = 16'hC2A7,
  parameter int          LANE      = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [ADDR_W:0] wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic            rd_en_i,
  input  logic [ADDR_W:0] rd_addr_i,
  output logic [7:0]      rd_data_o
);
  logic                         wr_hit, rd_hit;
  logic [ADDR_W-1:0]            wr_dev, rd_dev;
  logic [SLOTS-1:0]             slot_vld;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [SLOTS-1:0][7:0]        slot_data;
  mode_e                        mode_w;
  seq_e                         stage_w;
  logic                         buf_wr_w, commit_w;
  logic [7:0]                   arr_byte, rd_next, rd_q;

  nor_lane_map #(.ADDR_W(ADDR_W), .LANE(LANE)) u_wr_map (
    .bus_addr_i(wr_addr_i), .hit_o(wr_hit), .dev_addr_o(wr_dev));

  nor_lane_map #(.ADDR_W(ADDR_W), .LANE(LANE)) u_rd_map (
    .bus_addr_i(rd_addr_i), .hit_o(rd_hit), .dev_addr_o(rd_dev));

  nor_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i && wr_hit), .addr_i(wr_dev), .data_i(wr_data_i),
    .slot_vld_o(slot_vld), .slot_addr_o(slot_addr), .slot_data_o(slot_data),
    .mode_o(mode_w), .stage_o(stage_w));

  nor_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .QUIET_CYC(QUIET_CYC)) u_store (
    .clk_i, .rst_ni,
    .slot_vld_i(slot_vld), .slot_addr_i(slot_addr), .slot_data_i(slot_data),
    .rd_addr_i(rd_dev), .rd_byte_o(arr_byte),
    .buf_wr_o(buf_wr_w), .commit_o(commit_w));

  always_comb begin
    rd_next = 8'hFF;
    if (rd_hit) begin
      case (mode_w)
        MODE_ARRAY: rd_next = arr_byte;
        MODE_IDENT: begin
          if (rd_dev == '0)                rd_next = ID_CODE[15:8];
          else if (rd_dev == ADDR_W'(1))   rd_next = ID_CODE[7:0];
          else                             rd_next = 8'hFE;
        end
        default:    rd_next = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= 8'hFF;
    else if (rd_en_i) rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/nor_flash_seq_chk.sv
module nor_flash_seq_chk
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int QUIET_CYC = 10690,
  parameter int LANE      = 0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [ADDR_W:0] rd_addr_i,
  input logic [7:0]      rd_data_o,
  input mode_e           mode_i,
  input seq_e            stage_i,
  input logic            buf_wr_i,
  input logic            commit_i
);
  localparam int QC_W = $clog2(QUIET_CYC + 2) + 1;

  logic [QC_W-1:0] quiet_c;
  logic            off_lane;

  assign off_lane = (LANE == LANE_ODD && !rd_addr_i[0]) || (LANE == LANE_EVEN && rd_addr_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              quiet_c <= '0;
    else if (buf_wr_i)        quiet_c <= QC_W'(1);
    else if (commit_i)        quiet_c <= '0;
    else if (quiet_c != '0)   quiet_c <= quiet_c + 1'b1;
  end

  // R12
  lane_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && off_lane |=> rd_data_o == 8'hFF);
  // R13
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  // R8
  commit_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> quiet_c == QC_W'(QUIET_CYC));
  // R8
  commit_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_c == QC_W'(QUIET_CYC) |-> commit_i);
  // R6
  seq_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_i == SEQ_GOT2 |-> $past(stage_i) == SEQ_GOT1);
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mode_i));
  // R4
  ident_no_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_IDENT |-> !buf_wr_i);
endmodule

bind nor_flash_seq nor_flash_seq_chk #(.ADDR_W(ADDR_W), .QUIET_CYC(QUIET_CYC), .LANE(LANE)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .mode_i(mode_w), .stage_i(stage_w),
  .buf_wr_i(buf_wr_w), .commit_i(commit_w));

// File: tb/test_nor_flash_seq.sv
module test_nor_flash_seq;
  localparam int          AW = 8;
  localparam int          Q  = 16;
  localparam logic [15:0] ID = 16'hC2A7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          a_we = 0, a_re = 0, b_we = 0, b_re = 0;
  logic [AW:0]   a_wa = '0, a_ra = '0, b_wa = '0, b_ra = '0;
  logic [7:0]    a_wd = '0, b_wd = '0;
  logic [7:0]    a_rd, b_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] q;

  nor_flash_seq #(.ADDR_W(AW), .PAGE_W(3), .QUIET_CYC(Q), .ID_CODE(ID), .LANE(0)) i_nor_flash_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(a_we), .wr_addr_i(a_wa), .wr_data_i(a_wd),
    .rd_en_i(a_re), .rd_addr_i(a_ra), .rd_data_o(a_rd));

  nor_flash_seq #(.ADDR_W(AW), .PAGE_W(3), .QUIET_CYC(Q), .ID_CODE(ID), .LANE(2)) i_nor_flash_seq_odd (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(b_we), .wr_addr_i(b_wa), .wr_data_i(b_wd),
    .rd_en_i(b_re), .rd_addr_i(b_ra), .rd_data_o(b_rd));

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit s, input int a, input logic [7:0] d);
    if (!s) begin a_we = 1; a_wa = (AW+1)'(a); a_wd = d; end
    else    begin b_we = 1; b_wa = (AW+1)'(a); b_wd = d; end
    @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic rd(input bit s, input int a, output logic [7:0] r);
    if (!s) begin a_re = 1; a_ra = (AW+1)'(a); end
    else    begin b_re = 1; b_ra = (AW+1)'(a); end
    @(negedge clk);
    a_re = 0; b_re = 0;
    r = s ? b_rd : a_rd;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input bit s, input int ua, input int ub, input logic [7:0] c);
    wr(s, ua, 8'hAA); wr(s, ub, 8'h55); wr(s, ua, c);
  endtask

  task automatic cmp_range(input int lo, input int hi, input string tag);
    logic [7:0] r;
    for (int a = lo; a <= hi; a++) begin
      rd(0, a, r);
      chk(r, exp_mem[a], tag);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int a = 0; a < 256; a++) exp_mem[a] = 8'hFF;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(a_rd, 8'hFF, "R1 rd_data reset");
    cmp_range(0, 255, "R1 erased array");

    // R7: fill page 2, buffer invisible until commit
    for (int a = 16; a < 24; a++) wr(0, a, 8'(a) ^ 8'h3C);
    rd(0, 16, q); chk(q, 8'hFF, "R7 buffer not visible");
    idle(Q + 2);
    for (int a = 16; a < 24; a++) exp_mem[a] = 8'(a) ^ 8'h3C;
    cmp_range(16, 23, "R7 page committed");

    // R8/R13: commit exactly Q cycles after the write; read on commit edge sees old
    wr(0, 40, 8'h11);
    for (int k = 1; k <= Q + 2; k++) begin
      rd(0, 40, q);
      chk(q, (k > Q) ? 8'h11 : 8'hFF, "R8 R13 commit timing");
    end
    exp_mem[40] = 8'h11;

    // R8: whole page rewritten, unwritten bytes become FF
    wr(0, 17, 8'h5A); idle(Q + 2);
    for (int a = 16; a < 24; a++) exp_mem[a] = 8'hFF;
    exp_mem[17] = 8'h5A;
    cmp_range(16, 23, "R8 page erase on commit");

    // R9: restart and page retarget
    wr(0, 8, 8'h01); idle(Q - 3); wr(0, 33, 8'h02); idle(Q + 2);
    exp_mem[32] = 8'h01; exp_mem[33] = 8'h02;
    cmp_range(8, 15, "R9 old page untouched");
    cmp_range(32, 39, "R9 retargeted page");

    // R10: write on expiry cycle goes to a fresh buffer
    wr(0, 48, 8'h61); idle(Q - 1); wr(0, 57, 8'h72); idle(Q + 2);
    exp_mem[48] = 8'h61; exp_mem[57] = 8'h72;
    cmp_range(48, 63, "R10 commit with write");

    // R5: break after first step
    wr(0, 8'h55, 8'hAA); wr(0, 8'h52, 8'h77); idle(Q + 2);
    exp_mem[8'h52] = 8'h77; exp_mem[8'h55] = 8'hAA;
    cmp_range(8'h50, 8'h57, "R5 replay one");

    // R6: break after second step
    unlock(0, 8'h55, 8'hAA, 8'h00);
    idle(1);
    // the unlock above hit 0x55 on its third write: a no-op command, no data
    wr(0, 8'h55, 8'hAA); wr(0, 8'hAA, 8'h55); wr(0, 8'hA9, 8'h12); idle(Q + 2);
    exp_mem[8'hA9] = 8'h12; exp_mem[8'hAA] = 8'h55; exp_mem[8'hAD] = 8'hAA;
    cmp_range(8'hA8, 8'hAF, "R6 replay two");

    // R5: wrong data on second step
    wr(0, 8'h55, 8'hAA); wr(0, 8'hAA, 8'h66); idle(Q + 2);
    for (int a = 8'hA8; a <= 8'hAF; a++) exp_mem[a] = 8'hFF;
    exp_mem[8'hAA] = 8'h66; exp_mem[8'hAD] = 8'hAA;
    cmp_range(8'hA8, 8'hAF, "R5 wrong second byte");

    // R2/R4: identification mode
    unlock(0, 8'h55, 8'hAA, 8'h90);
    rd(0, 0, q); chk(q, ID[15:8], "R4 id high");
    rd(0, 1, q); chk(q, ID[7:0], "R4 id low");
    for (int a = 2; a < 256; a++) begin rd(0, a, q); chk(q, 8'hFE, "R4 id filler"); end
    rd(0, 9'h100, q); chk(q, ID[15:8], "R12 top bit ignored both lanes");
    wr(0, 3, 8'h33);
    unlock(0, 8'h55, 8'hAA, 8'hF0);
    idle(Q + 2);
    rd(0, 3, q); chk(q, 8'hFF, "R4 write ignored");
    rd(0, 8'h52, q); chk(q, 8'h77, "R2 back to normal");

    // R2: address modulo device size
    wr(0, 9'h1C0, 8'h4D); idle(Q + 2);
    exp_mem[8'hC0] = 8'h4D;
    rd(0, 8'hC0, q); chk(q, 8'h4D, "R2 address alias");

    // R3: alternate commands
    unlock(0, 8'h55, 8'hAA, 8'h80); unlock(0, 8'h55, 8'hAA, 8'h60);
    rd(0, 0, q); chk(q, ID[15:8], "R3 alt 60 ident");
    unlock(0, 8'h55, 8'hAA, 8'hF0);
    rd(0, 8'h52, q); chk(q, 8'h77, "R3 flag cleared, F0 works");
    unlock(0, 8'h55, 8'hAA, 8'h80); unlock(0, 8'h55, 8'hAA, 8'h90);
    rd(0, 8'h52, q); chk(q, 8'h77, "R3 90 ignored with flag");
    unlock(0, 8'h55, 8'hAA, 8'h90);
    rd(0, 1, q); chk(q, ID[7:0], "R3 flag consumed");
    unlock(0, 8'h55, 8'hAA, 8'hF0);

    // R11: boot-block mode
    unlock(0, 8'h55, 8'hAA, 8'h80); unlock(0, 8'h55, 8'hAA, 8'h40);
    rd(0, 8'h52, q); chk(q, 8'hFF, "R11 boot reads FF");
    wr(0, 8'h52, 8'h99);
    rd(0, 8'h52, q); chk(q, 8'h77, "R11 normal after write");
    idle(Q + 2);
    rd(0, 8'h52, q); chk(q, 8'h77, "R11 byte discarded");

    // R13: output holds without a read
    wr(0, 8'h60, 8'h01);
    idle(3);
    chk(a_rd, 8'h77, "R13 hold");
    idle(Q);
    exp_mem[8'h60] = 8'h01;

    cmp_range(0, 255, "R7 final sweep");

    // R12: odd-lane instance
    wr(1, 9'h021, 8'h44); wr(1, 9'h022, 8'h55); idle(Q + 2);
    rd(1, 9'h021, q); chk(q, 8'h44, "R12 odd lane write");
    rd(1, 9'h020, q); chk(q, 8'hFF, "R12 even lane read");
    rd(1, 9'h023, q); chk(q, 8'hFF, "R12 even write ignored");
    unlock(1, 9'h0AB, 9'h155, 8'h90);
    rd(1, 9'h001, q); chk(q, ID[15:8], "R12 shifted id high");
    rd(1, 9'h003, q); chk(q, ID[7:0], "R12 shifted id low");
    rd(1, 9'h000, q); chk(q, 8'hFF, "R12 other lane in id mode");

    summary();
  end
endmodule